// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time as BCD counters and presents it in the eight highest byte addresses of a 2K x 8 byte-wide memory space. Seven live counters hold seconds, minutes, hours, day of week, date, month and year. They advance by one second on each one-second tick while the oscillator stop bit is clear. Rollover is automatic and takes month length and leap years into account.

The host never reads the live counters directly. It sees a holding image of them, which is copied from the counters as a single unit after every tick. A control byte can freeze that image so that the host gets a coherent multi-byte read. It can also halt the image so the host can load a new time, which is then committed to all seven counters at once when the halt is released.

The host port is synchronous. Chip enable, write enable, an 11-bit byte address and a data byte are sampled on the rising clock edge. Read data appears one cycle after the read is issued.

Top module: `rtc_bytewide_clock`

## Requirements
- R1: After reset the stop bit is 1, the frequency-test bit is 0, the control byte is 00h, rdata is 00h, and the time is 00:00:00, day 01, date 01, month 01, year 00.
- R2: A read (cs=1, we=0) returns its byte on rdata one cycle later. Offset 0 (7F8h) is the control byte, with the commit-halt bit in bit 7, the freeze bit in bit 6, the calibration sign in bit 5 and the calibration magnitude in bits 4:0. It reads back exactly as written. A read of any address below 7F8h returns 00h.
- R3: The stop bit is bit 7 of the seconds byte (offset 1). While it is 1, ticks do not change the time. A write to offset 1 always updates the stop bit, whatever the commit-halt bit holds.
- R4: With the stop bit at 0, each tick adds one second to the live time. Carries ripple through the fields in BCD: seconds 00-59, minutes 00-59, hours 00-23, date, month 01-12, year 00-99.
- R5: The day of week (offset 4, bits 2:0) steps 01 to 07 and wraps to 01 together with the date carry. Bit 6 of offset 4 is the frequency-test bit, and a write to offset 4 always updates it.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. February wraps after 28, or after 29 when the year is divisible by 4.
- R7: The year wraps from 99 to 00 when December 31 rolls over.
- R8: In the cycle after a tick, if both the freeze bit and the commit-halt bit are 0, all seven time bytes of the holding image are replaced by the live time in one update.
- R9: While the freeze bit is 1, the holding image does not change. After the bit is cleared, the image stays as it is until the next tick refreshes it.
- R10: While the commit-halt bit is 1, host writes to offsets 1-7 load the holding image and ticks do not alter it. A control write that clears the bit loads all seven holding bytes into the live counters and discards any ticks counted while it was set.
- R11: While the commit-halt bit is 0, host writes to the time fields of offsets 1-7 have no effect on the time.
- R12: Unused high bits are masked on write and read as 0. Hours keep bits 5:0, day bits 2:0, date bits 5:0, month bits 4:0, seconds and minutes bits 6:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip enable for a host access in this cycle |
| we | input | 1 | 1 = write, 0 = read, valid while cs is 1 |
| addr | input | 11 | Byte address; the clock occupies 7F8h-7FFh |
| wdata | input | 8 | Write data byte |
| tick | input | 1 | One-cycle pulse marking one elapsed second |
| rdata | output | 8 | Read data, valid the cycle after a read |

## Verification
The assertion that the live counters hold legal BCD values within range assumes the host commits only valid BCD time values. The stimulus follows that rule: it writes out-of-range bytes such as FFh only while the commit-halt bit is set, and overwrites them with legal values before releasing the bit. The stability checks assume that a tick is a single-cycle pulse. The bench drives ticks only as isolated one-cycle pulses and leaves an idle cycle after each one before reading, so the refresh has landed.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 8;
    localparam int OFS_W     = $clog2(WIN_BYTES);

    // Byte offsets inside the clock window; the order is what the host decodes.
    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL,
        OFS_SEC,
        OFS_MIN,
        OFS_HOUR,
        OFS_DAY,
        OFS_DATE,
        OFS_MONTH,
        OFS_YEAR
    } reg_ofs_e;

    // Each field is kept as a full BCD byte; unused high bits stay 0.
    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } bcd_time_t;

    typedef struct packed {
        logic       wr_hold;    // halt image, commit on clear
        logic       rd_freeze;  // freeze image for coherent read
        logic       cal_sign;
        logic [4:0] cal_mag;
    } ctrl_t;

    localparam bcd_time_t TIME_RESET = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
        date: 8'h01, month: 8'h01, year: 8'h00
    };

    localparam logic [7:0] MASK_SEC   = 8'h7F;
    localparam logic [7:0] MASK_MIN   = 8'h7F;
    localparam logic [7:0] MASK_HOUR  = 8'h3F;
    localparam logic [7:0] MASK_DAY   = 8'h07;
    localparam logic [7:0] MASK_DATE  = 8'h3F;
    localparam logic [7:0] MASK_MONTH = 8'h1F;
    localparam logic [7:0] MASK_YEAR  = 8'hFF;

    function automatic logic [7:0] bcd2bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_at_top(input logic [7:0] v, input logic [7:0] top);
        return bcd2bin(v) >= bcd2bin(top);
    endfunction

    function automatic logic [7:0] bcd_advance(input logic [7:0] v, input logic [7:0] lo,
                                               input logic [7:0] top);
        return bcd_at_top(v, top) ? lo : bcd_inc(v);
    endfunction

    function automatic logic is_leap(input logic [7:0] year);
        return (bcd2bin(year) % 8'd4) == 8'd0;
    endfunction

    function automatic logic [7:0] bcd_last_date(input logic [7:0] month, input logic [7:0] year);
        case (month)
            8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic bcd_in_range(input logic [7:0] v, input logic [7:0] lo,
                                          input logic [7:0] top);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) &&
               (bcd2bin(v) >= bcd2bin(lo)) && (bcd2bin(v) <= bcd2bin(top));
    endfunction

endpackage

// File: rtl/rtc_live_counter.sv
`timescale 1ns/1ps
module rtc_live_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      advance,
    input  logic      load,
    input  bcd_time_t load_val,
    output bcd_time_t live
);

    bcd_time_t  cur_q;
    bcd_time_t  nxt;
    logic [7:0] date_top;
    logic [7:0] sec_n, min_n, hour_n, day_n, date_n, mon_n, year_n;
    logic       c_min, c_hour, c_day, c_mon, c_year;

    assign date_top = bcd_last_date(cur_q.month, cur_q.year);

    // Ripple carry: each field moves only when every field below it wraps.
    assign c_min  = advance && bcd_at_top(cur_q.sec, 8'h59);
    assign c_hour = c_min   && bcd_at_top(cur_q.min, 8'h59);
    assign c_day  = c_hour  && bcd_at_top(cur_q.hour, 8'h23);
    assign c_mon  = c_day   && bcd_at_top(cur_q.date, date_top);
    assign c_year = c_mon   && bcd_at_top(cur_q.month, 8'h12);

    assign sec_n  = bcd_advance(cur_q.sec,   8'h00, 8'h59);
    assign min_n  = bcd_advance(cur_q.min,   8'h00, 8'h59);
    assign hour_n = bcd_advance(cur_q.hour,  8'h00, 8'h23);
    assign day_n  = bcd_advance(cur_q.day,   8'h01, 8'h07);
    assign date_n = bcd_advance(cur_q.date,  8'h01, date_top);
    assign mon_n  = bcd_advance(cur_q.month, 8'h01, 8'h12);
    assign year_n = bcd_advance(cur_q.year,  8'h00, 8'h99);

    always_comb begin
        nxt = cur_q;
        if (advance) nxt.sec   = sec_n;
        if (c_min)   nxt.min   = min_n;
        if (c_hour)  nxt.hour  = hour_n;
        if (c_day) begin
            nxt.day  = day_n;
            nxt.date = date_n;
        end
        if (c_mon)   nxt.month = mon_n;
        if (c_year)  nxt.year  = year_n;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= TIME_RESET;
        else if (load)
            cur_q <= load_val;
        else
            cur_q <= nxt;
    end

    assign live = cur_q;

endmodule

// File: rtl/rtc_hold_file.sv
`timescale 1ns/1ps
module rtc_hold_file
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  reg_ofs_e          ofs,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    input  bcd_time_t         live,
    output bcd_time_t         hold,
    output ctrl_t             ctrl,
    output logic              stop,
    output logic              ftest,
    output logic              commit
);

    ctrl_t     ctrl_q;
    bcd_time_t hold_q;
    logic      stop_q;
    logic      ft_q;
    logic      refresh_due_q;
    logic      wr_ctrl;
    logic      wr_time;
    logic      refresh;

    assign wr_ctrl = host_wr && (ofs == OFS_CTRL);
    assign wr_time = host_wr && ctrl_q.wr_hold;
    assign commit  = wr_ctrl && ctrl_q.wr_hold && !wdata[7];
    // Decision uses the control state of the refresh cycle itself.
    assign refresh = refresh_due_q && !ctrl_q.wr_hold && !ctrl_q.rd_freeze;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q        <= '0;
            hold_q        <= TIME_RESET;
            stop_q        <= 1'b1;
            ft_q          <= 1'b0;
            refresh_due_q <= 1'b0;
        end else begin
            refresh_due_q <= tick;
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata);
            if (host_wr && (ofs == OFS_SEC))
                stop_q <= wdata[7];
            if (host_wr && (ofs == OFS_DAY))
                ft_q <= wdata[6];
            if (refresh) begin
                hold_q <= live;
            end else if (wr_time) begin
                case (ofs)
                    OFS_SEC:   hold_q.sec   <= wdata & MASK_SEC;
                    OFS_MIN:   hold_q.min   <= wdata & MASK_MIN;
                    OFS_HOUR:  hold_q.hour  <= wdata & MASK_HOUR;
                    OFS_DAY:   hold_q.day   <= wdata & MASK_DAY;
                    OFS_DATE:  hold_q.date  <= wdata & MASK_DATE;
                    OFS_MONTH: hold_q.month <= wdata & MASK_MONTH;
                    OFS_YEAR:  hold_q.year  <= wdata & MASK_YEAR;
                    default:   ;
                endcase
            end
        end
    end

    assign hold  = hold_q;
    assign ctrl  = ctrl_q;
    assign stop  = stop_q;
    assign ftest = ft_q;

endmodule

// File: rtl/rtc_read_mux.sv
`timescale 1ns/1ps
module rtc_read_mux
    import rtc_pkg::*;
(
    input  reg_ofs_e          ofs,
    input  bcd_time_t         hold,
    input  ctrl_t             ctrl,
    input  logic              stop,
    input  logic              ftest,
    output logic [BYTE_W-1:0] q
);

    always_comb begin
        case (ofs)
            OFS_CTRL:  q = ctrl;
            OFS_SEC:   q = hold.sec | {stop, 7'b0};
            OFS_MIN:   q = hold.min;
            OFS_HOUR:  q = hold.hour;
            OFS_DAY:   q = hold.day | {1'b0, ftest, 6'b0};
            OFS_DATE:  q = hold.date;
            OFS_MONTH: q = hold.month;
            default:   q = hold.year;
        endcase
    end

endmodule

// File: rtl/rtc_bytewide_clock.sv
`timescale 1ns/1ps
module rtc_bytewide_clock
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    output logic [BYTE_W-1:0] rdata
);

    logic              in_win;
    reg_ofs_e          ofs;
    logic              host_wr;
    logic              host_rd;
    bcd_time_t         live_time;
    bcd_time_t         hold_time;
    ctrl_t             ctrl_q;
    logic              stop_bit;
    logic              ft_bit;
    logic              commit;
    logic [BYTE_W-1:0] mux_q;

    // Clock window is the top WIN_BYTES addresses.
    assign in_win  = &addr[ADDR_W-1:OFS_W];
    assign ofs     = reg_ofs_e'(addr[OFS_W-1:0]);
    assign host_wr = cs && we && in_win;
    assign host_rd = cs && !we;

    rtc_hold_file u_hold (
        .clk    (clk),
        .rst    (rst),
        .host_wr(host_wr),
        .ofs    (ofs),
        .wdata  (wdata),
        .tick   (tick),
        .live   (live_time),
        .hold   (hold_time),
        .ctrl   (ctrl_q),
        .stop   (stop_bit),
        .ftest  (ft_bit),
        .commit (commit)
    );

    rtc_live_counter u_live (
        .clk     (clk),
        .rst     (rst),
        .advance (tick && !stop_bit),
        .load    (commit),
        .load_val(hold_time),
        .live    (live_time)
    );

    rtc_read_mux u_mux (
        .ofs  (ofs),
        .hold (hold_time),
        .ctrl (ctrl_q),
        .stop (stop_bit),
        .ftest(ft_bit),
        .q    (mux_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (host_rd)
            rdata <= in_win ? mux_q : '0;
    end

endmodule

// File: rtl/rtc_bytewide_clock_sva.sv
`timescale 1ns/1ps
module rtc_bytewide_clock_sva
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       we,
    input logic       in_win,
    input logic       tick,
    input logic       commit,
    input logic       stop,
    input logic       rd_freeze,
    input bcd_time_t  live,
    input bcd_time_t  hold,
    input logic [7:0] rdata
);

    a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cs && !we && !in_win) |=> (rdata == 8'h00));

    a_r3_stop_freezes_time: assert property (@(posedge clk) disable iff (rst)
        (stop && !commit) |=> $stable(live));

    a_r4_no_tick_no_motion: assert property (@(posedge clk) disable iff (rst)
        (!tick && !commit) |=> $stable(live));

    a_r4_live_in_range: assert property (@(posedge clk) disable iff (rst)
        bcd_in_range(live.sec, 8'h00, 8'h59) && bcd_in_range(live.min, 8'h00, 8'h59) &&
        bcd_in_range(live.hour, 8'h00, 8'h23) && bcd_in_range(live.day, 8'h01, 8'h07) &&
        bcd_in_range(live.date, 8'h01, 8'h31) && bcd_in_range(live.month, 8'h01, 8'h12) &&
        bcd_in_range(live.year, 8'h00, 8'h99));

    a_r9_freeze_holds_image: assert property (@(posedge clk) disable iff (rst)
        (rd_freeze && !(cs && we)) |=> $stable(hold));

    a_r10_commit_loads_image: assert property (@(posedge clk) disable iff (rst)
        commit |=> (live == $past(hold)));

endmodule

bind rtc_bytewide_clock rtc_bytewide_clock_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .we       (we),
    .in_win   (in_win),
    .tick     (tick),
    .commit   (commit),
    .stop     (stop_bit),
    .rd_freeze(ctrl_q.rd_freeze),
    .live     (live_time),
    .hold     (hold_time),
    .rdata    (rdata)
);

// File: tb/rtc_bytewide_clock_tb_top.sv
`timescale 1ns/1ps
module rtc_bytewide_clock_tb_top;

    localparam int ADDR_W = 11;
    localparam logic [ADDR_W-1:0] BASE = 11'h7F8;

    localparam logic [2:0] O_CTRL = 3'd0, O_SEC = 3'd1, O_MIN = 3'd2, O_HOUR = 3'd3,
                           O_DAY = 3'd4, O_DATE = 3'd5, O_MON = 3'd6, O_YEAR = 3'd7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              tick = 1'b0;
    logic [7:0]        rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    rtc_bytewide_clock #(.ADDR_W(ADDR_W)) dut_i (
        .clk  (clk),
        .rst  (rst),
        .cs   (cs),
        .we   (we),
        .addr (addr),
        .wdata(wdata),
        .tick (tick),
        .rdata(rdata)
    );

    // Driver: issue a read and push its expected byte into the scoreboard.
    task automatic rd_at(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        sb_q.push_back('{exp, tag});
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ofs, input logic [7:0] exp, input string tag);
        rd_at(BASE + {8'd0, ofs}, exp, tag);
    endtask

    task automatic wr(input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = BASE + {8'd0, ofs}; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_late(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y);
        wr(O_CTRL, 8'h80);
        wr(O_SEC, 8'h59); wr(O_MIN, 8'h59); wr(O_HOUR, 8'h23);
        wr(O_DATE, d); wr(O_MON, m); wr(O_YEAR, y);
        wr(O_CTRL, 8'h00);
    endtask

    // Monitor: pop and compare one item per completed read.
    initial begin
        forever begin
            @(posedge clk);
            if (cs && !we) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected read: actual %02h expected none", rdata);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    checks++;
                    if (rdata !== it.exp) begin
                        errors++;
                        $display("FAIL %s: actual %02h expected %02h", it.tag, rdata, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (rdata !== 8'h00) begin
            errors++;
            $display("FAIL R1 rdata in reset: actual %02h expected 00", rdata);
        end
        rst = 1'b0;

        // R1 reset image
        rd(O_CTRL, 8'h00, "R1 ctrl");
        rd(O_SEC,  8'h80, "R1 sec with stop");
        rd(O_MIN,  8'h00, "R1 min");
        rd(O_HOUR, 8'h00, "R1 hour");
        rd(O_DAY,  8'h01, "R1 day");
        rd(O_DATE, 8'h01, "R1 date");
        rd(O_MON,  8'h01, "R1 month");
        rd(O_YEAR, 8'h00, "R1 year");
        rd_at(11'h123, 8'h00, "R2 below window");
        rd_at(11'h7F7, 8'h00, "R2 just below window");

        // R3 stopped clock ignores ticks
        pulse_tick(3);
        rd(O_SEC, 8'h80, "R3 stopped");

        // R11 time write ignored without halt; R3/R5 control bits still land
        wr(O_MIN, 8'h45);
        rd(O_MIN, 8'h00, "R11 min write ignored");
        wr(O_SEC, 8'h00);
        rd(O_SEC, 8'h00, "R3 stop cleared");
        wr(O_DAY, 8'h47);
        rd(O_DAY, 8'h41, "R5 ftest set day kept");
        wr(O_DAY, 8'h01);
        rd(O_DAY, 8'h01, "R5 ftest cleared");

        // R4 R8 one tick
        pulse_tick(1);
        rd(O_SEC, 8'h01, "R4 R8 one second");
        rd(O_MIN, 8'h00, "R4 min unchanged");

        // R10 set time with halt, tick during halt
        wr(O_CTRL, 8'h80);
        wr(O_SEC, 8'h58); wr(O_MIN, 8'h59); wr(O_HOUR, 8'h23); wr(O_DAY, 8'h07);
        wr(O_DATE, 8'h28); wr(O_MON, 8'h02); wr(O_YEAR, 8'h23);
        rd(O_SEC, 8'h58, "R10 image written");
        pulse_tick(1);
        rd(O_SEC, 8'h58, "R10 tick does not touch image");
        rd(O_CTRL, 8'h80, "R2 ctrl halt readback");
        wr(O_CTRL, 8'h00);
        rd(O_SEC, 8'h58, "R10 after commit");
        pulse_tick(1);
        rd(O_SEC, 8'h59, "R10 counter started from commit");
        pulse_tick(1);
        rd(O_SEC,  8'h00, "R4 sec wrap");
        rd(O_MIN,  8'h00, "R4 min wrap");
        rd(O_HOUR, 8'h00, "R4 hour wrap");
        rd(O_DAY,  8'h01, "R5 day 07 to 01");
        rd(O_DATE, 8'h01, "R6 feb 28 nonleap");
        rd(O_MON,  8'h03, "R6 to march");
        rd(O_YEAR, 8'h23, "R8 year kept");

        // R6 leap year
        wr(O_CTRL, 8'h80); wr(O_DAY, 8'h03); wr(O_CTRL, 8'h00);
        set_late(8'h28, 8'h02, 8'h24);
        pulse_tick(1);
        rd(O_DATE, 8'h29, "R6 leap feb 29");
        rd(O_MON,  8'h02, "R6 leap still feb");
        rd(O_DAY,  8'h04, "R5 day step");
        set_late(8'h29, 8'h02, 8'h24);
        pulse_tick(1);
        rd(O_DATE, 8'h01, "R6 leap feb end");
        rd(O_MON,  8'h03, "R6 leap to march");

        // R6 30-day month, R7 year wrap
        set_late(8'h30, 8'h04, 8'h99);
        pulse_tick(1);
        rd(O_DATE, 8'h01, "R6 april 30 wrap");
        rd(O_MON,  8'h05, "R6 to may");
        set_late(8'h30, 8'h12, 8'h99);
        pulse_tick(1);
        rd(O_DATE, 8'h31, "R6 december 31");
        set_late(8'h31, 8'h12, 8'h99);
        pulse_tick(1);
        rd(O_DATE, 8'h01, "R6 december wrap");
        rd(O_MON,  8'h01, "R7 month to january");
        rd(O_YEAR, 8'h00, "R7 year 99 to 00");
        rd(O_DAY,  8'h01, "R5 day wrap again");

        // R9 freeze for read
        wr(O_CTRL, 8'h40);
        pulse_tick(2);
        rd(O_SEC, 8'h00, "R9 frozen image");
        rd(O_CTRL, 8'h40, "R2 ctrl freeze readback");
        wr(O_CTRL, 8'h65);
        rd(O_CTRL, 8'h65, "R2 calibration readback");
        wr(O_CTRL, 8'h05);
        rd(O_SEC, 8'h00, "R9 no refresh before tick");
        pulse_tick(1);
        rd(O_SEC, 8'h03, "R9 refresh resumes");

        // R12 masking
        wr(O_CTRL, 8'h80);
        wr(O_HOUR, 8'hFF);
        rd(O_HOUR, 8'h3F, "R12 hour mask");
        wr(O_MON, 8'hFF);
        rd(O_MON, 8'h1F, "R12 month mask");
        wr(O_DAY, 8'hFF);
        rd(O_DAY, 8'h47, "R12 day mask with ftest");
        wr(O_HOUR, 8'h10); wr(O_MON, 8'h06); wr(O_DAY, 8'h02);
        rd(O_DAY, 8'h02, "R12 day restored");
        wr(O_CTRL, 8'h00);
        pulse_tick(1);
        rd(O_SEC,  8'h04, "R10 commit kept refreshed sec");
        rd(O_HOUR, 8'h10, "R10 hour committed");
        rd(O_MON,  8'h06, "R10 month committed");

        // R11 and R3 again
        wr(O_MIN, 8'h33);
        rd(O_MIN, 8'h00, "R11 min ignored");
        wr(O_YEAR, 8'h55);
        rd(O_YEAR, 8'h00, "R11 year ignored");
        wr(O_SEC, 8'h80);
        rd(O_SEC, 8'h84, "R3 stop set keeps sec");
        pulse_tick(2);
        rd(O_SEC, 8'h84, "R3 stopped again");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule